// File: doc/BRIEF.md
# Frame Readout Address Sequencer

This block walks the pixel array of an image sensor in readout order and produces one row/column address pair at a time for the downstream readout path. A single-cycle start pulse opens a frame; from then on the consumer takes addresses at its own pace with an advance strobe. Once the last address of the frame has been taken, the block signals completion and waits for the next start pulse.

Each frame is shaped by a configuration that is captured at the start pulse. Rows may be traversed bottom-up (vertical mirror). A rectangular window picks a column range and a row range. A decimation setting keeps one pixel in 1, 2, 4 or 8 on both axes, starting at the window origin. Decimation spreads its samples over the whole window, so the field of view is preserved. Start and size values that fall outside the array are pulled back inside it. A smaller window therefore gives a shorter frame. Column mirroring is left to the image consumer.

Per-line and per-frame first/last flags come with each address, so the consumer can insert line and frame markers without counting on its own.

Top module: `frame_addr_seq`

## Requirements
- R1: While reset is applied and after it is released, `addr_valid_o` and `frame_done_o` are 0 until a start pulse arrives.
- R2: A `sof_i` pulse seen while idle makes `addr_valid_o` go to 1 on the next cycle. The first address is the window origin, and `line_first_o` and `frame_first_o` are both 1 with it.
- R3: Addresses go in raster order. Each accepted address (`addr_valid_o` and `adv_i` both 1 at a clock edge) moves to the next column. After the last column of a line, the column returns to the line start and the row moves on. While `adv_i` is 0, the address and all flags hold.
- R4: `cfg_sub_i` selects the decimation factor: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. It applies to both axes. The kept columns are start, start+f, and so on, up to the window's last column. Rows follow the same rule.
- R5: With `cfg_flip_i` = 1, rows start at the window's last row and go down by the factor while they stay at or above the window's first row. Column order is not affected.
- R6: Clamping is done per axis. A start at or beyond the extent becomes extent-1. A size of 0 becomes 1. A size that reaches past the array is cut so that the window ends at extent-1.
- R7: Configuration inputs are used only at the accepted start pulse. Changes to them during a frame, and `sof_i` pulses while `addr_valid_o` is 1, have no effect on that frame.
- R8: `line_last_o` is 1 on the last column of every line. `frame_last_o` is 1 only on the final address. Once the final address is accepted, `addr_valid_o` falls and `frame_done_o` is 1 for exactly that one cycle.
- R9: A frame consists of ceil(cols/f) x ceil(rows/f) accepted addresses, where cols and rows are the clamped window sizes. A window with fewer rows therefore ends earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse |
| adv_i | input | 1 | Consumer accepts the current address |
| cfg_flip_i | input | 1 | Traverse rows bottom-up |
| cfg_sub_i | input | 2 | Decimation code (0..3 -> 1,2,4,8) |
| cfg_col_start_i | input | CW | Window first column |
| cfg_col_size_i | input | CW | Window width in columns |
| cfg_row_start_i | input | RW | Window first row |
| cfg_row_size_i | input | RW | Window height in rows |
| addr_valid_o | output | 1 | Address is presented |
| row_addr_o | output | RW | Row index |
| col_addr_o | output | CW | Column index |
| line_first_o | output | 1 | First column of a line |
| line_last_o | output | 1 | Last column of a line |
| frame_first_o | output | 1 | First address of the frame |
| frame_last_o | output | 1 | Final address of the frame |
| frame_done_o | output | 1 | One-cycle pulse after the final address is accepted |

## Verification
The assertions assume three things about the inputs: `sof_i` is a single-cycle pulse, `adv_i` is meaningful only while an address is presented, and the configuration is settled in the cycle of the start pulse. The directed tasks drive every input on the falling edge. They raise `sof_i` for exactly one cycle, with the configuration already applied in that cycle. They assert `adv_i` only while expecting a valid address. Configuration changes and extra start pulses are injected during a frame on purpose, to show that they are ignored.

// File: rtl/frame_addr_pkg.sv
package frame_addr_pkg;
  typedef enum logic [1:0] {
    SUB_BY1 = 2'd0,
    SUB_BY2 = 2'd1,
    SUB_BY4 = 2'd2,
    SUB_BY8 = 2'd3
  } sub_code_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SCAN = 1'b1
  } seq_state_e;
endpackage

// File: rtl/axis_clamp.sv
// Pulls one axis' window start/size inside [0, EXT-1] and returns its bounds.
module axis_clamp #(
  parameter int EXT = 1920,
  parameter int W   = $clog2(EXT + 1)
) (
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] size_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  localparam logic [W:0] EXT_X = EXT[W:0];
  localparam logic [W:0] ONE   = 1;

  logic [W:0] st, sz, room, top;

  always_comb begin
    st = {1'b0, start_i};
    if (st >= EXT_X) st = EXT_X - ONE;
    sz = {1'b0, size_i};
    if (sz == '0) sz = ONE;
    room = EXT_X - st;
    if (sz > room) sz = room;
    top  = st + sz - ONE;
    lo_o = st[W-1:0];
    hi_o = top[W-1:0];
  end
endmodule

// File: rtl/axis_walk.sv
// One axis position register that captures its own bounds at load time.
module axis_walk #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         rewind_i,
  input  logic         step_i,
  input  logic         down_i,
  input  logic [1:0]   shift_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] pos_o,
  output logic         first_o,
  output logic         last_o
);
  localparam logic [W:0] ONE = 1;

  logic [W-1:0] lo_q, lo_d, hi_q, hi_d, pos_q, pos_d;
  logic [1:0]   shift_q, shift_d;
  logic         down_q, down_d, first_q, first_d, armed_q, armed_d;
  logic [W:0]   stride, up_sum, dn_gap;

  assign stride = ONE << shift_q;
  assign up_sum = {1'b0, pos_q} + stride;
  assign dn_gap = {1'b0, pos_q} - {1'b0, lo_q};
  assign last_o = down_q ? (dn_gap < stride) : (up_sum > {1'b0, hi_q});
  assign pos_o  = pos_q;
  assign first_o = first_q;

  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    down_d  = down_q;
    shift_d = shift_q;
    pos_d   = pos_q;
    first_d = first_q;
    armed_d = armed_q;
    if (load_i) begin
      lo_d    = lo_i;
      hi_d    = hi_i;
      down_d  = down_i;
      shift_d = shift_i;
      pos_d   = down_i ? hi_i : lo_i;
      first_d = 1'b1;
      armed_d = 1'b1;
    end else if (rewind_i) begin
      pos_d   = down_q ? hi_q : lo_q;
      first_d = 1'b1;
    end else if (step_i) begin
      pos_d   = down_q ? (pos_q - stride[W-1:0]) : up_sum[W-1:0];
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      down_q  <= 1'b0;
      shift_q <= 2'd0;
      pos_q   <= '0;
      first_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      down_q  <= down_d;
      shift_q <= shift_d;
      pos_q   <= pos_d;
      first_q <= first_d;
      armed_q <= armed_d;
    end
  end

  // R4: once loaded, the position never leaves the captured window
  a_r4_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (pos_q >= lo_q) && (pos_q <= hi_q));

  // R5: a plain step moves strictly in the captured direction
  a_r5_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && step_i && !load_i && !rewind_i && !last_o) |=>
      (down_q ? (pos_q < $past(pos_q)) : (pos_q > $past(pos_q))));
endmodule

// File: rtl/frame_addr_seq.sv
module frame_addr_seq
  import frame_addr_pkg::*;
#(
  parameter int COLS = 1920,
  parameter int ROWS = 1080,
  parameter int CW   = $clog2(COLS + 1),
  parameter int RW   = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof_i,
  input  logic          adv_i,
  input  logic          cfg_flip_i,
  input  logic [1:0]    cfg_sub_i,
  input  logic [CW-1:0] cfg_col_start_i,
  input  logic [CW-1:0] cfg_col_size_i,
  input  logic [RW-1:0] cfg_row_start_i,
  input  logic [RW-1:0] cfg_row_size_i,
  output logic          addr_valid_o,
  output logic [RW-1:0] row_addr_o,
  output logic [CW-1:0] col_addr_o,
  output logic          line_first_o,
  output logic          line_last_o,
  output logic          frame_first_o,
  output logic          frame_last_o,
  output logic          frame_done_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic [CW-1:0] col_lo, col_hi, col_pos;
  logic [RW-1:0] row_lo, row_hi, row_pos;
  logic          col_first, col_last, row_first, row_last;
  logic          load, col_rewind, col_step, row_step;
  seq_state_e    state_q, state_d;
  logic          done_q, done_d;

  axis_clamp #(.EXT(COLS), .W(CW)) u_col_clamp (
    .start_i(cfg_col_start_i), .size_i(cfg_col_size_i),
    .lo_o(col_lo), .hi_o(col_hi));

  axis_clamp #(.EXT(ROWS), .W(RW)) u_row_clamp (
    .start_i(cfg_row_start_i), .size_i(cfg_row_size_i),
    .lo_o(row_lo), .hi_o(row_hi));

  axis_walk #(.W(CW)) u_col_walk (
    .clk(clk), .rst_n(rst_s), .load_i(load), .rewind_i(col_rewind),
    .step_i(col_step), .down_i(1'b0), .shift_i(cfg_sub_i),
    .lo_i(col_lo), .hi_i(col_hi), .pos_o(col_pos),
    .first_o(col_first), .last_o(col_last));

  axis_walk #(.W(RW)) u_row_walk (
    .clk(clk), .rst_n(rst_s), .load_i(load), .rewind_i(1'b0),
    .step_i(row_step), .down_i(cfg_flip_i), .shift_i(cfg_sub_i),
    .lo_i(row_lo), .hi_i(row_hi), .pos_o(row_pos),
    .first_o(row_first), .last_o(row_last));

  always_comb begin
    state_d    = state_q;
    done_d     = 1'b0;
    load       = 1'b0;
    col_rewind = 1'b0;
    col_step   = 1'b0;
    row_step   = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (sof_i) begin
          load    = 1'b1;
          state_d = SEQ_SCAN;
        end
      end
      SEQ_SCAN: begin
        if (adv_i) begin
          if (!col_last) begin
            col_step = 1'b1;
          end else if (!row_last) begin
            col_rewind = 1'b1;
            row_step   = 1'b1;
          end else begin
            done_d  = 1'b1;
            state_d = SEQ_IDLE;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign addr_valid_o  = (state_q == SEQ_SCAN);
  assign row_addr_o    = row_pos;
  assign col_addr_o    = col_pos;
  assign line_first_o  = addr_valid_o & col_first;
  assign line_last_o   = addr_valid_o & col_last;
  assign frame_first_o = addr_valid_o & col_first & row_first;
  assign frame_last_o  = addr_valid_o & col_last & row_last;
  assign frame_done_o  = done_q;

  // R3: a stalled consumer sees a frozen address
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (addr_valid_o && !adv_i) |=>
      addr_valid_o && $stable(row_addr_o) && $stable(col_addr_o));

  // R3: inside a line only the column moves
  a_r3_same_row: assert property (@(posedge clk) disable iff (!rst_s)
    (addr_valid_o && adv_i && !line_last_o) |=>
      addr_valid_o && $stable(row_addr_o));

  // R7: a start pulse during a frame does not disturb it
  a_r7_sof_busy: assert property (@(posedge clk) disable iff (!rst_s)
    (addr_valid_o && sof_i && !(adv_i && frame_last_o)) |=> addr_valid_o);

  // R8: completion pulse coincides with the end of addresses and lasts one cycle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_s)
    frame_done_o |-> !addr_valid_o);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_s)
    frame_done_o |=> !frame_done_o);

  a_r8_last_to_done: assert property (@(posedge clk) disable iff (!rst_s)
    (addr_valid_o && adv_i && frame_last_o) |=> frame_done_o);
endmodule

// File: tb/frame_addr_seq_test.sv
module frame_addr_seq_test;
  localparam int COLS = 40;
  localparam int ROWS = 24;
  localparam int CW = $clog2(COLS + 1);
  localparam int RW = $clog2(ROWS + 1);

  logic clk = 1'b0;
  logic rst_n, sof, adv, flip;
  logic [1:0] sub;
  logic [CW-1:0] cs, csz;
  logic [RW-1:0] rs, rsz;
  logic valid, lf, ll, ff, fl, done;
  logic [RW-1:0] row;
  logic [CW-1:0] col;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  frame_addr_seq #(.COLS(COLS), .ROWS(ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .adv_i(adv),
    .cfg_flip_i(flip), .cfg_sub_i(sub),
    .cfg_col_start_i(cs), .cfg_col_size_i(csz),
    .cfg_row_start_i(rs), .cfg_row_size_i(rsz),
    .addr_valid_o(valid), .row_addr_o(row), .col_addr_o(col),
    .line_first_o(lf), .line_last_o(ll), .frame_first_o(ff),
    .frame_last_o(fl), .frame_done_o(done));

  task automatic expect_out(string req, bit ev, int er, int ec,
                            bit elf, bit ell, bit eff, bit efl, bit edn);
    bit bad;
    checks++;
    bad = (valid !== ev) || (lf !== elf) || (ll !== ell) ||
          (ff !== eff) || (fl !== efl) || (done !== edn);
    if (ev && ((int'(row) != er) || (int'(col) != ec))) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL %s: got v=%b r=%0d c=%0d lf=%b ll=%b ff=%b fl=%b dn=%b, expected v=%b r=%0d c=%0d lf=%b ll=%b ff=%b fl=%b dn=%b",
               req, valid, row, col, lf, ll, ff, fl, done,
               ev, er, ec, elf, ell, eff, efl, edn);
    end
  endtask

  task automatic clamp(int ext, int st, int sz, output int lo, output int n);
    lo = (st >= ext) ? ext - 1 : st;
    n  = (sz == 0) ? 1 : sz;
    if (n > ext - lo) n = ext - lo;
  endtask

  // Runs one frame and checks every address and the completion pulse.
  task automatic run_frame(string req, int c0, int cn, int r0, int rn, int s,
                           bit fl_i, bit stall, bit poke, output int cycles);
    int clo, cnum, rlo, rnum, f, nc, nr;
    clamp(COLS, c0, cn, clo, cnum);
    clamp(ROWS, r0, rn, rlo, rnum);
    f  = 1 << s;
    nc = (cnum + f - 1) / f;
    nr = (rnum + f - 1) / f;
    @(negedge clk);
    cs = CW'(c0); csz = CW'(cn); rs = RW'(r0); rsz = RW'(rn);
    sub = 2'(s); flip = fl_i; sof = 1'b1; adv = 1'b0;
    @(negedge clk);
    sof = 1'b0;
    cycles = 1;
    for (int i = 0; i < nr; i++) begin
      for (int j = 0; j < nc; j++) begin
        int er;
        er = fl_i ? (rlo + rnum - 1 - i * f) : (rlo + i * f);
        if (stall && ((i * nc + j) % 3 == 1)) begin
          adv = 1'b0;
          @(negedge clk);
          cycles++;
        end
        expect_out(req, 1'b1, er, clo + j * f, j == 0, j == nc - 1,
                   (i == 0) && (j == 0), (i == nr - 1) && (j == nc - 1), 1'b0);
        adv = 1'b1;
        if (poke && i == 0 && j == 0) begin
          sof = 1'b1; flip = ~fl_i; sub = 2'(s + 1);
          cs = '0; csz = '0; rs = '0; rsz = '0;
        end
        @(negedge clk);
        cycles++;
        adv = 1'b0;
        sof = 1'b0;
      end
    end
    expect_out({req, " R8 done"}, 1'b0, 0, 0, 0, 0, 0, 0, 1'b1);
    @(negedge clk);
    expect_out({req, " R8 single pulse"}, 1'b0, 0, 0, 0, 0, 0, 0, 1'b0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; sof = 1'b0; adv = 1'b0; flip = 1'b0; sub = 2'd0;
    cs = '0; csz = '0; rs = '0; rsz = '0;
    repeat (3) @(negedge clk);
    expect_out("R1 in reset", 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_out("R1 after release", 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic test_plain();
    int cyc;
    run_frame("R2 R3 R8 plain window", 3, 5, 2, 3, 0, 0, 0, 0, cyc);
  endtask

  task automatic test_sub_stall();
    int cyc;
    run_frame("R3 R4 sub2 with stalls", 1, 9, 4, 7, 1, 0, 1, 0, cyc);
  endtask

  task automatic test_flip();
    int cyc;
    run_frame("R5 R4 flip sub4", 6, 13, 3, 11, 2, 1, 0, 0, cyc);
    run_frame("R5 flip sub1", 0, 4, 20, 4, 0, 1, 1, 0, cyc);
  endtask

  task automatic test_full_sub8();
    int cyc;
    run_frame("R4 full array sub8", 0, COLS, 0, ROWS, 3, 1, 0, 0, cyc);
  endtask

  task automatic test_clamp();
    int cyc;
    run_frame("R6 start past edge, size zero", 50, 0, 30, 3, 0, 0, 0, 0, cyc);
    run_frame("R6 size truncated", 36, 20, 20, 10, 2, 1, 0, 0, cyc);
  endtask

  task automatic test_ignore();
    int cyc;
    run_frame("R7 mid-frame sof and config", 2, 6, 5, 4, 1, 0, 0, 1, cyc);
  endtask

  task automatic test_length();
    int tall, short_;
    run_frame("R9 tall window", 4, 6, 0, 6, 0, 0, 0, 0, tall);
    run_frame("R9 short window", 4, 6, 0, 2, 0, 0, 0, 0, short_);
    checks++;
    if (tall != 37 || short_ != 13) begin
      errors++;
      $display("FAIL R9 frame length: got %0d/%0d cycles, expected 37/13",
               tall, short_);
    end
  endtask

  initial begin
    test_reset();
    test_plain();
    test_sub_stall();
    test_flip();
    test_full_sub8();
    test_clamp();
    test_ignore();
    test_length();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule